// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Controller

This block sits beside the CSR file of a single-hart 32-bit core that runs only in machine mode. Each cycle it looks at the retiring instruction's flags from decode: environment call, breakpoint and trap return. It also watches an external interrupt line and the live values of the status, trap-vector and exception-PC registers. From these it decides whether the core enters a trap, returns from one, or carries on as normal.

When a trap is taken, the block writes the status, exception-PC and cause registers and redirects the program counter to the handler base. On a trap return it restores the interrupt enable and redirects to the saved exception PC. Its own CSR writes take precedence over any CSR instruction writing the same register in that cycle. Its redirect also wins over every other next-PC source (a jump or branch target, or the sequential address).

An external interrupt is held pending until interrupts are enabled and a valid instruction retires with no synchronous event beside it. It then takes the place of the following instruction.

Top module: `mtrap_ctrl`

## Requirements
- R1: With no trap, no return and no pending interrupt, `redirect_valid` is 0, the block writes no CSR, and `pc_next` equals `jump_target` when `jump_valid` is 1, otherwise `pc_plus4`.
- R2: A valid instruction flagged `is_ecall` takes a trap with cause 11. A valid instruction flagged `is_ebreak` takes a trap with cause 3. In both cases the saved exception PC is `instr_pc`.
- R3: On any trap entry, the status write copies bit 3 (interrupt enable) into bit 7 (previous enable), clears bit 3, sets bits 12:11 (previous privilege) to 2'b11, and keeps every other bit of `mstatus_in`.
- R4: The trap target is `mtvec_in` with bits 1:0 forced to zero (direct mode).
- R5: An `ext_irq` pulse sets a pending flag on the next clock edge. The flag stays set until the interrupt is accepted, then clears.
- R6: A pending interrupt is accepted only when `mstatus_in` bit 3 is 1, `instr_valid` is 1, and none of `is_ecall`, `is_ebreak` or `is_mret` is set. It writes cause 0x8000000B. The saved exception PC is the address the PC would otherwise have advanced to: `jump_target` if `jump_valid` is 1, else `pc_plus4`.
- R7: A valid instruction flagged `is_mret` sets bit 3 from bit 7, sets bit 7 to 1, holds bits 12:11 at 2'b11, and redirects to `mepc_in`. It writes neither the exception PC nor the cause register.
- R8: A CSR instruction write (`csr_we`) to address 0x300, 0x341 or 0x342 reaches the status, exception-PC or cause write port respectively, unless the block writes that same register in the same cycle. In that case the block's value wins.
- R9: Whenever `redirect_valid` is 1, `pc_next` equals `redirect_pc`, regardless of `jump_valid`.
- R10: After a trap entry taken with status 0x1808 and a matching trap return, the status value reads 0x1888.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq | input | 1 | Machine external interrupt request |
| instr_valid | input | 1 | An instruction retires this cycle |
| is_ecall | input | 1 | Retiring instruction is an environment call |
| is_ebreak | input | 1 | Retiring instruction is a breakpoint |
| is_mret | input | 1 | Retiring instruction is a trap return |
| instr_pc | input | 32 | Address of the retiring instruction |
| mstatus_in | input | 32 | Live status register |
| mtvec_in | input | 32 | Live trap-vector register |
| mepc_in | input | 32 | Live exception-PC register |
| csr_we | input | 1 | CSR instruction write enable |
| csr_addr | input | 12 | CSR instruction write address |
| csr_wdata | input | 32 | CSR instruction write data |
| jump_valid | input | 1 | Jump or taken branch this cycle |
| jump_target | input | 32 | Jump or branch target |
| pc_plus4 | input | 32 | Sequential next address |
| redirect_valid | output | 1 | Trap entry or return redirects the PC |
| redirect_pc | output | 32 | Redirect target |
| pc_next | output | 32 | Selected next PC |
| mstatus_we | output | 1 | Status write enable |
| mstatus_wd | output | 32 | Status write data |
| mepc_we | output | 1 | Exception-PC write enable |
| mepc_wd | output | 32 | Exception-PC write data |
| mcause_we | output | 1 | Cause write enable |
| mcause_wd | output | 32 | Cause write data |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, three arbitrated CSRs, and cause codes 11, 3 and 11 with the interrupt flag. At these values, the actual cause and address encodings can be compared literally, and the full enter-then-return status sequence ending at 0x1888 can be checked. The bench also covers the corners where events collide. These include an interrupt held back first by a cleared enable and then by a simultaneous environment call, a CSR write losing to a trap on the same register, and a jump losing to a redirect.

// File: rtl/mtrap_pkg.sv
// Shared constants and types of the machine-mode trap controller.
// Assumes a machine-only hart with a 32-bit status layout.
package mtrap_pkg;
    // status bit positions
    localparam int unsigned ST_IE   = 3;
    localparam int unsigned ST_PIE  = 7;
    localparam int unsigned ST_PPLO = 11;
    localparam int unsigned ST_PPHI = 12;

    // CSR addresses that this block arbitrates
    localparam logic [11:0] ADR_STATUS = 12'h300;
    localparam logic [11:0] ADR_EPC    = 12'h341;
    localparam logic [11:0] ADR_CAUSE  = 12'h342;

    // index of each arbitrated CSR in the write-port arrays
    localparam int unsigned IX_STATUS = 0;
    localparam int unsigned IX_EPC    = 1;
    localparam int unsigned IX_CAUSE  = 2;
    localparam int unsigned N_CSR     = 3;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_IRQ,
        EV_ECALL,
        EV_EBREAK,
        EV_RETURN
    } trap_ev_e;
endpackage

// File: rtl/mtrap_irq_hold.sv
// Pending-interrupt holder: captures a request and keeps it until accepted.
// Assumes the request may be a single-cycle pulse.
module mtrap_irq_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_in,
    input  logic accept,
    output logic pending
);
    logic pend_q;

    // set on request, clear on acceptance, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q | irq_in) & ~accept;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/mtrap_event_sel.sv
// Chooses the single trap event of the cycle.
// Synchronous events of the retiring instruction outrank the interrupt.
// An interrupt needs the enable bit and a valid instruction to replace.
module mtrap_event_sel
    import mtrap_pkg::*;
(
    input  logic     instr_valid,
    input  logic     is_ecall,
    input  logic     is_ebreak,
    input  logic     is_mret,
    input  logic     pending,
    input  logic     irq_enable,
    output trap_ev_e event_kind,
    output logic     irq_take
);
    logic sync_any;

    // any synchronous event from the retiring instruction
    always_comb begin
        sync_any = instr_valid & (is_ecall | is_ebreak | is_mret);
    end

    // priority pick: ecall, ebreak, return, then interrupt
    always_comb begin
        irq_take   = 1'b0;
        event_kind = EV_NONE;
        if (instr_valid && is_ecall) begin
            event_kind = EV_ECALL;
        end else if (instr_valid && is_ebreak) begin
            event_kind = EV_EBREAK;
        end else if (instr_valid && is_mret) begin
            event_kind = EV_RETURN;
        end else if (pending && irq_enable && instr_valid && !sync_any) begin
            event_kind = EV_IRQ;
            irq_take   = 1'b1;
        end
    end
endmodule

// File: rtl/mtrap_csr_arb.sv
// Per-CSR write arbitration: the trap controller's write overrides a CSR
// instruction write to the same register. One lane per register.
module mtrap_csr_arb #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NREG = 3,
    parameter int unsigned AW   = 12,
    parameter logic [NREG-1:0][AW-1:0] ADDRS = '0
) (
    input  logic [NREG-1:0]           own_we,
    input  logic [NREG-1:0][XLEN-1:0] own_wd,
    input  logic                      ins_we,
    input  logic [AW-1:0]             ins_addr,
    input  logic [XLEN-1:0]           ins_wd,
    output logic [NREG-1:0]           out_we,
    output logic [NREG-1:0][XLEN-1:0] out_wd
);
    for (genvar g = 0; g < NREG; g++) begin : g_lane
        logic hit;
        // address match of the instruction write for this lane
        always_comb hit = ins_we && (ins_addr == ADDRS[g]);
        // own write first, instruction write second
        always_comb begin
            out_we[g] = own_we[g] | hit;
            out_wd[g] = own_we[g] ? own_wd[g] : ins_wd;
        end
    end
endmodule

// File: rtl/mtrap_pc_sel.sv
// Next-PC selection: redirect over jump over sequential address.
// Also exposes the address the PC would take with no redirect.
module mtrap_pc_sel #(
    parameter int unsigned XLEN = 32
) (
    input  logic            redirect_valid,
    input  logic [XLEN-1:0] redirect_pc,
    input  logic            jump_valid,
    input  logic [XLEN-1:0] jump_target,
    input  logic [XLEN-1:0] pc_plus4,
    output logic [XLEN-1:0] flow_pc,
    output logic [XLEN-1:0] pc_next
);
    // ordinary program-flow successor
    always_comb flow_pc = jump_valid ? jump_target : pc_plus4;

    // redirect takes absolute priority
    always_comb pc_next = redirect_valid ? redirect_pc : flow_pc;
endmodule

// File: rtl/mtrap_ctrl.sv
// Machine-mode trap entry and return controller (top).
// Decides trap events, forms status/epc/cause writes, arbitrates them
// against CSR instruction writes and selects the next PC.
// Assumes direct-mode vectoring and machine mode only.
module mtrap_ctrl
    import mtrap_pkg::*;
#(
    parameter int unsigned XLEN       = 32,
    parameter int unsigned CODE_IRQ   = 11,
    parameter int unsigned CODE_ECALL = 11,
    parameter int unsigned CODE_BRK   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_irq,
    input  logic            instr_valid,
    input  logic            is_ecall,
    input  logic            is_ebreak,
    input  logic            is_mret,
    input  logic [XLEN-1:0] instr_pc,
    input  logic [XLEN-1:0] mstatus_in,
    input  logic [XLEN-1:0] mtvec_in,
    input  logic [XLEN-1:0] mepc_in,
    input  logic            csr_we,
    input  logic [11:0]     csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    input  logic            jump_valid,
    input  logic [XLEN-1:0] jump_target,
    input  logic [XLEN-1:0] pc_plus4,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] pc_next,
    output logic            mstatus_we,
    output logic [XLEN-1:0] mstatus_wd,
    output logic            mepc_we,
    output logic [XLEN-1:0] mepc_wd,
    output logic            mcause_we,
    output logic [XLEN-1:0] mcause_wd
);
    localparam logic [XLEN-1:0] VEC_MASK  = ~XLEN'(3);
    localparam logic [XLEN-1:0] IRQ_FLAG  = XLEN'(1) << (XLEN - 1);
    localparam logic [XLEN-1:0] CAUSE_IRQ = IRQ_FLAG | XLEN'(CODE_IRQ);
    localparam logic [XLEN-1:0] CAUSE_EC  = XLEN'(CODE_ECALL);
    localparam logic [XLEN-1:0] CAUSE_BK  = XLEN'(CODE_BRK);
    localparam logic [N_CSR-1:0][11:0] ARB_ADDRS = {ADR_CAUSE, ADR_EPC, ADR_STATUS};

    logic     pending;
    logic     irq_take;
    trap_ev_e ev;
    logic     entering;
    logic [XLEN-1:0] flow_pc;
    logic [XLEN-1:0] st_enter;
    logic [XLEN-1:0] st_return;
    logic [N_CSR-1:0]           own_we;
    logic [N_CSR-1:0][XLEN-1:0] own_wd;
    logic [N_CSR-1:0]           arb_we;
    logic [N_CSR-1:0][XLEN-1:0] arb_wd;

    mtrap_irq_hold u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (ext_irq),
        .accept  (irq_take),
        .pending (pending)
    );

    mtrap_event_sel u_sel (
        .instr_valid (instr_valid),
        .is_ecall    (is_ecall),
        .is_ebreak   (is_ebreak),
        .is_mret     (is_mret),
        .pending     (pending),
        .irq_enable  (mstatus_in[ST_IE]),
        .event_kind  (ev),
        .irq_take    (irq_take)
    );

    // entry covers interrupt and both synchronous traps
    always_comb entering = (ev == EV_IRQ) || (ev == EV_ECALL) || (ev == EV_EBREAK);

    // status value on trap entry: stash enable, disable, privilege to machine
    always_comb begin
        st_enter          = mstatus_in;
        st_enter[ST_PIE]  = mstatus_in[ST_IE];
        st_enter[ST_IE]   = 1'b0;
        st_enter[ST_PPHI] = 1'b1;
        st_enter[ST_PPLO] = 1'b1;
    end

    // status value on trap return: restore enable, re-arm stash
    always_comb begin
        st_return          = mstatus_in;
        st_return[ST_IE]   = mstatus_in[ST_PIE];
        st_return[ST_PIE]  = 1'b1;
        st_return[ST_PPHI] = 1'b1;
        st_return[ST_PPLO] = 1'b1;
    end

    // own CSR write requests per event
    always_comb begin
        own_we = '0;
        own_wd = '0;
        own_we[IX_STATUS] = entering || (ev == EV_RETURN);
        own_wd[IX_STATUS] = (ev == EV_RETURN) ? st_return : st_enter;
        own_we[IX_EPC]    = entering;
        own_wd[IX_EPC]    = (ev == EV_IRQ) ? flow_pc : instr_pc;
        own_we[IX_CAUSE]  = entering;
        unique case (ev)
            EV_IRQ:    own_wd[IX_CAUSE] = CAUSE_IRQ;
            EV_ECALL:  own_wd[IX_CAUSE] = CAUSE_EC;
            EV_EBREAK: own_wd[IX_CAUSE] = CAUSE_BK;
            default:   own_wd[IX_CAUSE] = '0;
        endcase
    end

    // redirect request and its target
    always_comb begin
        redirect_valid = entering || (ev == EV_RETURN);
        redirect_pc    = (ev == EV_RETURN) ? mepc_in : (mtvec_in & VEC_MASK);
    end

    mtrap_csr_arb #(
        .XLEN  (XLEN),
        .NREG  (N_CSR),
        .AW    (12),
        .ADDRS (ARB_ADDRS)
    ) u_arb (
        .own_we   (own_we),
        .own_wd   (own_wd),
        .ins_we   (csr_we),
        .ins_addr (csr_addr),
        .ins_wd   (csr_wdata),
        .out_we   (arb_we),
        .out_wd   (arb_wd)
    );

    mtrap_pc_sel #(.XLEN(XLEN)) u_pc (
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .jump_valid     (jump_valid),
        .jump_target    (jump_target),
        .pc_plus4       (pc_plus4),
        .flow_pc        (flow_pc),
        .pc_next        (pc_next)
    );

    // break out arbitrated ports
    always_comb begin
        mstatus_we = arb_we[IX_STATUS];
        mstatus_wd = arb_wd[IX_STATUS];
        mepc_we    = arb_we[IX_EPC];
        mepc_wd    = arb_wd[IX_EPC];
        mcause_we  = arb_we[IX_CAUSE];
        mcause_wd  = arb_wd[IX_CAUSE];
    end
endmodule

// File: rtl/mtrap_ctrl_chk.sv
// Property checker for the trap controller, bound to every instance.
module mtrap_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        instr_valid,
    input logic        is_mret,
    input logic        is_ecall,
    input logic        is_ebreak,
    input logic [31:0] mstatus_in,
    input logic [31:0] mepc_in,
    input logic        redirect_valid,
    input logic [31:0] redirect_pc,
    input logic [31:0] pc_next,
    input logic [31:0] mstatus_wd,
    input logic        pending,
    input logic        irq_take
);
    // R9
    redirect_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> (pc_next == redirect_pc));

    // R6
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (mstatus_in[3] && instr_valid && !is_ecall && !is_ebreak && !is_mret));

    // R5
    pending_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !irq_take) |=> pending);

    // R5
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> pending);

    // R3
    entry_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !(instr_valid && is_mret)) |->
            (!mstatus_wd[3] && mstatus_wd[12:11] == 2'b11 && mstatus_wd[7] == mstatus_in[3]));

    // R7
    return_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && is_mret && !is_ecall && !is_ebreak) |->
            (redirect_valid && redirect_pc == mepc_in && mstatus_wd[3] == mstatus_in[7]));
endmodule

bind mtrap_ctrl mtrap_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .instr_valid    (instr_valid),
    .is_mret        (is_mret),
    .is_ecall       (is_ecall),
    .is_ebreak      (is_ebreak),
    .mstatus_in     (mstatus_in),
    .mepc_in        (mepc_in),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .pc_next        (pc_next),
    .mstatus_wd     (mstatus_wd),
    .pending        (pending),
    .irq_take       (irq_take)
);

// File: tb/sim_mtrap_ctrl.sv
// Directed bench for the trap controller; one task per scenario.
module sim_mtrap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_irq = 1'b0, instr_valid = 1'b0;
    logic        is_ecall = 1'b0, is_ebreak = 1'b0, is_mret = 1'b0;
    logic [31:0] instr_pc = 32'h0000_0100;
    logic [31:0] mstatus_in = 32'h0000_1808;
    logic [31:0] mtvec_in = 32'h8000_0101;
    logic [31:0] mepc_in = 32'h0000_0200;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = 12'h000;
    logic [31:0] csr_wdata = 32'h0;
    logic        jump_valid = 1'b0;
    logic [31:0] jump_target = 32'h0000_0400;
    logic [31:0] pc_plus4 = 32'h0000_0104;
    logic        redirect_valid;
    logic [31:0] redirect_pc, pc_next;
    logic        mstatus_we, mepc_we, mcause_we;
    logic [31:0] mstatus_wd, mepc_wd, mcause_wd;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    localparam logic [31:0] VEC = 32'h8000_0100;

    always #10 clk = ~clk;

    mtrap_ctrl u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ext_irq = 0; instr_valid = 0; is_ecall = 0; is_ebreak = 0; is_mret = 0;
        csr_we = 0; jump_valid = 0; mstatus_in = 32'h0000_1808;
    endtask

    task automatic t_reset();
        idle(); instr_valid = 1; #2;
        chk("R1 no redirect", {31'b0, redirect_valid}, 32'd0);
        chk("R1 no writes", {29'b0, mstatus_we, mepc_we, mcause_we}, 32'd0);
        chk("R1 sequential", pc_next, 32'h0000_0104);
        jump_valid = 1; #2;
        chk("R1 jump", pc_next, 32'h0000_0400);
    endtask

    task automatic t_ecall();
        idle(); instr_valid = 1; is_ecall = 1; #2;
        chk("R2 ecall cause", mcause_wd, 32'd11);
        chk("R2 ecall epc", mepc_wd, 32'h0000_0100);
        chk("R4 vector", redirect_pc, VEC);
        chk("R3 entry status", mstatus_wd, 32'h0000_1880);
        chk("R9 next pc", pc_next, VEC);
    endtask

    task automatic t_ebreak();
        idle(); instr_valid = 1; is_ebreak = 1; mstatus_in = 32'hFFFF_FFFF; jump_valid = 1; #2;
        chk("R2 ebreak cause", mcause_wd, 32'd3);
        chk("R3 other bits kept", mstatus_wd, 32'hFFFF_FFF7);
        chk("R9 redirect beats jump", pc_next, VEC);
    endtask

    task automatic t_irq_basic();
        idle(); ext_irq = 1; #2;
        chk("R5 no take before latch", {31'b0, redirect_valid}, 32'd0);
        idle(); instr_valid = 1; jump_valid = 1; #2;
        chk("R6 irq taken", {31'b0, redirect_valid}, 32'd1);
        chk("R6 irq cause", mcause_wd, 32'h8000_000B);
        chk("R6 irq epc flow", mepc_wd, 32'h0000_0400);
        idle(); instr_valid = 1; #2;
        chk("R5 cleared after accept", {31'b0, redirect_valid}, 32'd0);
    endtask

    task automatic t_irq_masked();
        idle(); ext_irq = 1;
        for (int i = 0; i < 3; i++) begin
            idle(); instr_valid = 1; mstatus_in = 32'h0000_1800; #2;
            chk("R6 masked no take", {31'b0, redirect_valid}, 32'd0);
        end
        idle(); instr_valid = 1; is_ecall = 1; #2;
        chk("R6 ecall outranks irq", mcause_wd, 32'd11);
        idle(); instr_valid = 1; #2;
        chk("R5 held then taken", mcause_wd, 32'h8000_000B);
        chk("R6 irq epc seq", mepc_wd, 32'h0000_0104);
    endtask

    task automatic t_mret();
        idle(); instr_valid = 1; is_mret = 1; mstatus_in = 32'h0000_1880; #2;
        chk("R7 target", redirect_pc, 32'h0000_0200);
        chk("R10 final status", mstatus_wd, 32'h0000_1888);
        chk("R7 no epc/cause write", {30'b0, mepc_we, mcause_we}, 32'd0);
        mstatus_in = 32'h0000_1800; #2;
        chk("R7 pie set", mstatus_wd, 32'h0000_1880);
    endtask

    task automatic t_csr_arb();
        idle(); instr_valid = 1; csr_we = 1; csr_addr = 12'h341; csr_wdata = 32'hDEAD_BEEF; #2;
        chk("R8 epc passthrough we", {31'b0, mepc_we}, 32'd1);
        chk("R8 epc passthrough wd", mepc_wd, 32'hDEAD_BEEF);
        chk("R8 other ports idle", {30'b0, mstatus_we, mcause_we}, 32'd0);
        csr_addr = 12'h342; is_ecall = 1; #2;
        chk("R8 trap wins cause", mcause_wd, 32'd11);
        is_ecall = 0; is_mret = 1; mstatus_in = 32'h0000_1880; csr_addr = 12'h300; #2;
        chk("R8 return wins status", mstatus_wd, 32'h0000_1888);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ecall();
        t_ebreak();
        t_irq_basic();
        t_irq_masked();
        t_mret();
        t_csr_arb();
        idle();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule